// File: doc/BRIEF.md
# SPI Controller Interrupt Register Bank

This block holds the interrupt-related registers of an SPI controller that has transmit and receive FIFOs. It watches the two FIFO occupancy counts, compares them against two programmable watermark registers and against the full depth, and turns the results into level status bits. It also captures receive-overflow and transmit-underflow event pulses in sticky bits. A per-bit mask, built through separate set-only and clear-only write registers, selects which status bits drive one registered interrupt line.

Software reaches the block through a small single-cycle register port. A driver typically sets the transmit watermark to 1, so that the "transmit below watermark" bit means "transmit FIFO empty". It then enables that bit together with the receive-level bit and services the FIFOs from the interrupt. The FIFOs and the shift engine sit outside this block. Only their occupancy counts and event pulses come in.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the mask is zero, the transmit watermark reads 1, the receive watermark reads 32, both sticky bits are clear, `irq` is low, and `reg_rdata` is zero.
- R2: Status bit 2 is one exactly when `tx_level` is less than the transmit watermark (offset 0x28).
- R3: Status bit 3 is one exactly when `tx_level` equals DEPTH, and status bit 5 is one exactly when `rx_level` equals DEPTH.
- R4: Status bit 4 is one exactly when `rx_level` is greater than or equal to the receive watermark (offset 0x2C).
- R5: Status bit 0 (receive overflow) and status bit 6 (transmit underflow) are set by their event pulse. Each stays set until a write to the status offset 0x04 has a one in that bit position. If the pulse and the clearing write fall in the same cycle, the bit ends up set.
- R6: Writing ones to status bits 2 to 5 has no effect; those bits keep following the FIFO levels.
- R7: A write to offset 0x08 sets the mask bits where the data has ones. A write to offset 0x0C clears the mask bits where the data has ones. All other mask bits keep their value. The mask reads back at offset 0x10.
- R8: Reads of 0x08, 0x0C and any unmapped offset return zero. Mask bit 1 and every bit above bit 6 of status and mask read as zero.
- R9: `irq` equals the OR of (status AND mask) as it stood before the previous clock edge, so it lags by one register.
- R10: Each watermark register stores the low LVL_W bits of the written data and reads back zero above them. Read data appears on `reg_rdata` one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_ovf_pulse | input | 1 | Receive overflow event |
| tx_udf_pulse | input | 1 | Transmit underflow event |
| irq | output | 1 | Registered interrupt request |

## Verification
Read data is due on the first falling edge after the rising edge that captured `reg_rd`. A level change applied on a falling edge is therefore already visible in the next read. Sticky bits and mask writes take effect at the rising edge that captures them, and `irq` follows one rising edge later. The bench drives every stimulus on a falling edge, samples reads on the following falling edge, and waits one extra rising edge before it checks `irq`. Both level counts are swept over their full range 0 to DEPTH for several watermark values, and all 128 mask patterns are checked against the expected interrupt.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NBITS = 7;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_IEN  = 8'h08;
  localparam logic [7:0] OFS_IDIS = 8'h0C;
  localparam logic [7:0] OFS_IMSK = 8'h10;
  localparam logic [7:0] OFS_TXWM = 8'h28;
  localparam logic [7:0] OFS_RXWM = 8'h2C;
  localparam int B_RXOVF  = 0;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXAVL  = 4;
  localparam int B_RXFULL = 5;
  localparam int B_TXUDF  = 6;
  localparam logic [NBITS-1:0] VALID_BITS = 7'b111_1101;
endpackage

// File: rtl/spi_irq_level_flags.sv
module spi_irq_level_flags
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_wm,
  input  logic [LVL_W-1:0] rx_wm,
  output logic [NBITS-1:0] lvl_bits
);
  localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(DEPTH);

  always_comb begin
    lvl_bits           = '0;
    lvl_bits[B_TXLOW]  = (tx_level < tx_wm);
    lvl_bits[B_TXFULL] = (tx_level == FULL_CNT);
    lvl_bits[B_RXAVL]  = (rx_level >= rx_wm);
    lvl_bits[B_RXFULL] = (rx_level == FULL_CNT);
  end
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (ev[i])  q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int LVL_W    = $clog2(DEPTH + 1),
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TXWM_RST = 1,
  parameter int RXWM_RST = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_ovf_pulse,
  input  logic              tx_udf_pulse,
  output logic              irq
);
  localparam int USED_W = (LVL_W > NBITS) ? LVL_W : NBITS;

  logic wr_stat, wr_ien, wr_idis, wr_txwm, wr_rxwm;
  logic [NBITS-1:0] lvl_bits, status, mask_q;
  logic [1:0] sticky_q;
  logic [LVL_W-1:0] tx_wm_q, rx_wm_q;
  logic [DATA_W-1:0] rd_mux;
  logic unused_hi;

  assign unused_hi = ^reg_wdata[DATA_W-1:USED_W];

  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
  assign wr_ien  = reg_wr && (reg_addr == ADDR_W'(OFS_IEN));
  assign wr_idis = reg_wr && (reg_addr == ADDR_W'(OFS_IDIS));
  assign wr_txwm = reg_wr && (reg_addr == ADDR_W'(OFS_TXWM));
  assign wr_rxwm = reg_wr && (reg_addr == ADDR_W'(OFS_RXWM));

  spi_irq_level_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) flags_i (
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_wm    (tx_wm_q),
    .rx_wm    (rx_wm_q),
    .lvl_bits (lvl_bits)
  );

  spi_irq_sticky #(.N(2)) sticky_i (
    .clk (clk),
    .rst (rst),
    .ev  ({tx_udf_pulse, rx_ovf_pulse}),
    .clr ({wr_stat & reg_wdata[B_TXUDF], wr_stat & reg_wdata[B_RXOVF]}),
    .q   (sticky_q)
  );

  always_comb begin
    status          = lvl_bits;
    status[B_RXOVF] = sticky_q[0];
    status[B_TXUDF] = sticky_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_ien)  mask_q <= mask_q | (reg_wdata[NBITS-1:0] & VALID_BITS);
    else if (wr_idis) mask_q <= mask_q & ~reg_wdata[NBITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wm_q <= LVL_W'(TXWM_RST);
      rx_wm_q <= LVL_W'(RXWM_RST);
    end else begin
      if (wr_txwm) tx_wm_q <= reg_wdata[LVL_W-1:0];
      if (wr_rxwm) rx_wm_q <= reg_wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_STAT))      rd_mux = DATA_W'(status);
    else if (reg_addr == ADDR_W'(OFS_IMSK)) rd_mux = DATA_W'(mask_q);
    else if (reg_addr == ADDR_W'(OFS_TXWM)) rd_mux = DATA_W'(tx_wm_q);
    else if (reg_addr == ADDR_W'(OFS_RXWM)) rd_mux = DATA_W'(rx_wm_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask_q);
  end
endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              rx_ovf_pulse,
  input logic              irq,
  input logic [NBITS-1:0]  mask_q,
  input logic [1:0]        sticky_q
);
  localparam int RD_W = (LVL_W > NBITS) ? LVL_W : NBITS;

  // R5: an overflow event always leaves the sticky bit set
  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    rx_ovf_pulse |=> sticky_q[0]);

  // R5: the bit survives any cycle without a clearing write
  a_r5_ovf_holds: assert property (@(posedge clk) disable iff (rst)
    (sticky_q[0] && !(reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[B_RXOVF]))
    |=> sticky_q[0]);

  // R7: enable write sets the requested valid bits
  a_r7_enable: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_IEN))
    |=> ((mask_q & $past(reg_wdata[NBITS-1:0] & VALID_BITS)) ==
         $past(reg_wdata[NBITS-1:0] & VALID_BITS)));

  // R7: disable write clears the requested bits
  a_r7_disable: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_IDIS))
    |=> ((mask_q & $past(reg_wdata[NBITS-1:0])) == '0));

  // R8: nothing above the implemented fields ever reads back
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata >> RD_W) == '0);

  // R9: an empty mask keeps the interrupt low one cycle later
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);
endmodule

bind spi_irq_regs spi_irq_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .rx_ovf_pulse (rx_ovf_pulse),
  .irq          (irq),
  .mask_q       (mask_q),
  .sticky_q     (sticky_q)
);

// File: tb/spi_irq_regs_tb.sv
module spi_irq_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic rx_ovf_pulse = 1'b0, tx_udf_pulse = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_regs #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level),
    .rx_ovf_pulse(rx_ovf_pulse), .tx_udf_pulse(tx_udf_pulse), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_stat(int tx, int rx, int txwm, int rxwm,
                                           bit ovf, bit udf);
    logic [31:0] v = '0;
    v[0] = ovf;
    v[2] = (tx < txwm);
    v[3] = (tx == DEPTH);
    v[4] = (rx >= rxwm);
    v[5] = (rx == DEPTH);
    v[6] = udf;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int wms[5] = '{0, 1, 5, 63, 64};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rdata", reg_rdata, 32'd0);
    rd(8'h10, d); check("R1 mask", d, 32'd0);
    rd(8'h28, d); check("R1 txwm", d, 32'd1);
    rd(8'h2C, d); check("R1 rxwm", d, 32'd32);
    rd(8'h04, d); check("R1 status", d, exp_stat(0, 0, 1, 32, 0, 0));

    // R2 R3 transmit sweep
    foreach (wms[k]) begin
      wr(8'h28, 32'(wms[k]));
      for (int t = 0; t <= DEPTH; t++) begin
        tx_level = LVL_W'(t);
        rd(8'h04, d);
        check("R2/R3 tx sweep", d, exp_stat(t, 0, wms[k], 32, 0, 0));
      end
    end

    // R4 R3 receive sweep
    wr(8'h28, 32'd1);
    tx_level = 7'd10;
    foreach (wms[k]) begin
      wr(8'h2C, 32'(wms[k]));
      for (int r = 0; r <= DEPTH; r++) begin
        rx_level = LVL_W'(r);
        rd(8'h04, d);
        check("R4/R3 rx sweep", d, exp_stat(10, r, 1, wms[k], 0, 0));
      end
    end

    // R10 watermark width
    wr(8'h28, 32'hFFFF_FFAB);
    rd(8'h28, d); check("R10 txwm width", d, 32'h2B);
    wr(8'h2C, 32'h1234_5681);
    rd(8'h2C, d); check("R10 rxwm width", d, 32'h01);

    // R6: writing ones to level bits has no effect
    wr(8'h28, 32'd1); wr(8'h2C, 32'd32);
    tx_level = 7'd64; rx_level = 7'd64;
    wr(8'h04, 32'h3C);
    rd(8'h04, d); check("R6 level bits not clearable", d, exp_stat(64, 64, 1, 32, 0, 0));
    tx_level = 7'd0; rx_level = 7'd0;

    // R5 sticky events
    @(negedge clk); rx_ovf_pulse = 1'b1;
    @(negedge clk); rx_ovf_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h04, d); check("R5 ovf sticky", d, exp_stat(0, 0, 1, 32, 1, 0));
    @(negedge clk); tx_udf_pulse = 1'b1;
    @(negedge clk); tx_udf_pulse = 1'b0;
    rd(8'h04, d); check("R5 udf sticky", d, exp_stat(0, 0, 1, 32, 1, 1));
    wr(8'h04, 32'h40);
    rd(8'h04, d); check("R5 clear udf only", d, exp_stat(0, 0, 1, 32, 1, 0));
    wr(8'h04, 32'h01);
    rd(8'h04, d); check("R5 clear ovf", d, exp_stat(0, 0, 1, 32, 0, 0));
    @(negedge clk);
    rx_ovf_pulse = 1'b1; reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h01;
    @(negedge clk);
    rx_ovf_pulse = 1'b0; reg_wr = 1'b0;
    rd(8'h04, d); check("R5 set wins over clear", d, exp_stat(0, 0, 1, 32, 1, 0));
    wr(8'h04, 32'h01);

    // R7 R8 R9 mask patterns and interrupt
    tx_level = 7'd64; rx_level = 7'd3;
    @(negedge clk); tx_udf_pulse = 1'b1;
    @(negedge clk); tx_udf_pulse = 1'b0;
    for (int m = 0; m < 128; m++) begin
      logic [31:0] st;
      st = exp_stat(64, 3, 1, 32, 0, 1);
      wr(8'h0C, 32'h7F);
      wr(8'h08, 32'(m));
      @(posedge clk); @(negedge clk);
      check("R9 irq", {31'd0, irq}, {31'd0, |(st[6:0] & 7'(m))});
      rd(8'h10, d); check("R7/R8 mask readback", d, 32'(m) & 32'h7D);
    end
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R8 mask reserved bits", d, 32'h7D);
    wr(8'h0C, 32'h0000_0014);
    rd(8'h10, d); check("R7 partial disable", d, 32'h69);
    rd(8'h08, d); check("R8 enable reads zero", d, 32'd0);
    rd(8'h0C, d); check("R8 disable reads zero", d, 32'd0);
    rd(8'h00, d); check("R8 unmapped 0x00", d, 32'd0);
    rd(8'hFC, d); check("R8 unmapped 0xFC", d, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule